// File: doc/BRIEF.md
# Event Counter with Shared Indicator Pin

This block counts performance events in a 40-bit register. Software can preset the count at any time. It can count in two ways. In occurrence mode it adds the number of events reported in each clock, which is at most two. In duration mode it adds one for every clock in which a condition input is high. A one-cycle overflow pulse leaves the block a fixed number of clocks after the count wraps past its top value. This lets software use the block as a "count up to N" trigger by presetting the counter to 2^40 minus N.

The block drives one registered external indicator pin, and that pin has several uses. In increment-indicate mode it marks the clocks in which the counter advanced. In overflow-indicate mode it repeats the delayed overflow pulse. A breakpoint-mode select overrides both of these and routes the breakpoint-match input to the pin. Counting carries on underneath while breakpoint mode is selected.

Top module: `evt_tally_pin`

## Requirements
- R1: After reset, `count_q` is 0, `ovf_pulse` is 0 and `ind_pin` is 0.
- R2: When `load_en` is high at a clock edge, `count_q` takes `load_val` at that edge. No event is added in that cycle, and that cycle produces no overflow.
- R3: When `cnt_en` is high, `dur_mode` is 0 and `load_en` is 0, `count_q` advances by `evt_num` at each edge. The codes are 0, 1 and 2, and code 3 is treated as 2.
- R4: When `cnt_en` is high, `dur_mode` is 1 and `load_en` is 0, `count_q` advances by 1 at each edge where `cond_true` is high. In this mode `evt_num` is ignored.
- R5: When `cnt_en` is 0 and `load_en` is 0, `count_q` holds its value whatever `evt_num` and `cond_true` do.
- R6: The count wraps modulo 2^40, and an edge whose sum passes 2^40-1 is a wrap. For example, 2^40-1 plus 2 gives 1 and still counts as a wrap.
- R7: `ovf_pulse` is high for exactly one cycle per wrap. It goes high after the fifth clock edge, counting the wrapping edge as the first. That is 4 cycles after `count_q` shows the wrapped value.
- R8: With `bkpt_mode`=0, `cnt_en`=1, `pin_ovf`=0 and `dur_mode`=0, `ind_pin` is high for the one cycle after each edge at which the counter advanced. It gives a single high cycle even when 2 events were added.
- R9: With `bkpt_mode`=0, `cnt_en`=1, `pin_ovf`=0 and `dur_mode`=1, `ind_pin` follows `cond_true` one cycle late. It stays high for as long as the condition lasts.
- R10: With `bkpt_mode`=0, `cnt_en`=1 and `pin_ovf`=1, `ind_pin` is high in exactly the cycles where `ovf_pulse` is high.
- R11: With `bkpt_mode`=1, `ind_pin` equals `bkpt_hit` one cycle late, and no increment or overflow indication reaches it. Counting itself is unaffected.
- R12: With `bkpt_mode`=0 and `cnt_en`=0, `ind_pin` is 0 after the next edge. This holds even when an overflow pulse is still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counting enable |
| dur_mode | input | 1 | 1 = duration counting, 0 = occurrence counting |
| pin_ovf | input | 1 | 1 = pin shows overflow, 0 = pin shows increments |
| bkpt_mode | input | 1 | 1 = pin shows breakpoint matches |
| evt_num | input | 2 | Events seen this clock (0..2, 3 acts as 2) |
| cond_true | input | 1 | Duration condition level |
| load_en | input | 1 | Preset strobe |
| load_val | input | 40 | Preset value |
| bkpt_hit | input | 1 | Breakpoint match input |
| count_q | output | 40 | Current count |
| ovf_pulse | output | 1 | Delayed one-cycle overflow pulse |
| ind_pin | output | 1 | Registered shared indicator pin |

## Verification
A preset and an overflow can land close together in time. A preset strobe may coincide with events that would have wrapped the counter. A fresh preset or a change of pin mode may also arrive while an earlier wrap is still travelling down the five-stage delay. The bench provokes these by loading values within a few counts of 2^40-1 and then applying one- and two-event codes. It also strobes preset and disable in the middle of the delay window. A behavioural model holds the pending wraps in a queue, and every clock it judges the count, the pulse and the pin against that model.

// File: rtl/evt_tally_pkg.sv
package evt_tally_pkg;
   typedef enum logic [1:0] {
      PIN_OFF  = 2'd0,
      PIN_STEP = 2'd1,
      PIN_OVF  = 2'd2,
      PIN_BKPT = 2'd3
   } pin_src_e;
endpackage

// File: rtl/evt_tally_accum.sv
module evt_tally_accum #(
   parameter int CNT_W   = 40,
   parameter int EVT_W   = 2,
   parameter int MAX_EVT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             dur_mode,
   input  logic [EVT_W-1:0] evt_num,
   input  logic             cond_true,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count_q,
   output logic             carry_o,
   output logic             step_o
);
   localparam logic [EVT_W-1:0] MAX_V = EVT_W'(MAX_EVT);

   generate
      if (MAX_EVT < 1 || MAX_EVT >= (1 << EVT_W)) begin : g_bad_max
         $error("MAX_EVT must fit in EVT_W bits and be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_w
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic [EVT_W-1:0] occ_amt;
   logic [EVT_W-1:0] amt;
   logic [CNT_W:0]   sum;

   always_comb begin
      occ_amt = (evt_num > MAX_V) ? MAX_V : evt_num;
      if (!en)
         amt = '0;
      else if (dur_mode)
         amt = EVT_W'(cond_true);
      else
         amt = occ_amt;
      sum     = {1'b0, count_q} + (CNT_W+1)'(amt);
      carry_o = !load_en && sum[CNT_W];
      step_o  = !load_en && (amt != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         count_q <= '0;
      else if (load_en)
         count_q <= load_val;
      else
         count_q <= sum[CNT_W-1:0];
   end
endmodule

// File: rtl/evt_tally_dly.sv
module evt_tally_dly #(
   parameter int DEPTH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic last_o,
   output logic prev_o
);
   generate
      if (DEPTH < 1) begin : g_bad
         $error("DEPTH must be at least 1");
      end else if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) last_o <= 1'b0;
            else        last_o <= d_i;
         end
         assign prev_o = d_i;
      end else begin : g_chain
         logic [DEPTH-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[DEPTH-2:0], d_i};
         end
         assign last_o = stage_q[DEPTH-1];
         assign prev_o = stage_q[DEPTH-2];
      end
   endgenerate
endmodule

// File: rtl/evt_tally_pinmux.sv
module evt_tally_pinmux
   import evt_tally_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bkpt_mode,
   input  logic bkpt_hit,
   input  logic en,
   input  logic ovf_mode,
   input  logic step,
   input  logic ovf_early,
   output logic pin_q
);
   pin_src_e src;
   logic     pin_d;

   always_comb begin
      if (bkpt_mode)     src = PIN_BKPT;
      else if (!en)      src = PIN_OFF;
      else if (ovf_mode) src = PIN_OVF;
      else               src = PIN_STEP;
      unique case (src)
         PIN_BKPT: pin_d = bkpt_hit;
         PIN_OVF:  pin_d = ovf_early;
         PIN_STEP: pin_d = step;
         default:  pin_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_d;
   end
endmodule

// File: rtl/evt_tally_pin.sv
module evt_tally_pin #(
   parameter int CNT_W   = 40,
   parameter int EVT_W   = 2,
   parameter int MAX_EVT = 2,
   parameter int OVF_DLY = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             dur_mode,
   input  logic             pin_ovf,
   input  logic             bkpt_mode,
   input  logic [EVT_W-1:0] evt_num,
   input  logic             cond_true,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             bkpt_hit,
   output logic [CNT_W-1:0] count_q,
   output logic             ovf_pulse,
   output logic             ind_pin
);
   logic carry;
   logic step;
   logic ovf_early;

   evt_tally_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W), .MAX_EVT(MAX_EVT)) u_accum (
      .clk(clk), .rst_n(rst_n), .en(cnt_en), .dur_mode(dur_mode),
      .evt_num(evt_num), .cond_true(cond_true), .load_en(load_en),
      .load_val(load_val), .count_q(count_q), .carry_o(carry), .step_o(step)
   );

   evt_tally_dly #(.DEPTH(OVF_DLY)) u_dly (
      .clk(clk), .rst_n(rst_n), .d_i(carry),
      .last_o(ovf_pulse), .prev_o(ovf_early)
   );

   evt_tally_pinmux u_pin (
      .clk(clk), .rst_n(rst_n), .bkpt_mode(bkpt_mode), .bkpt_hit(bkpt_hit),
      .en(cnt_en), .ovf_mode(pin_ovf), .step(step), .ovf_early(ovf_early),
      .pin_q(ind_pin)
   );
endmodule

// File: rtl/evt_tally_chk.sv
module evt_tally_chk #(
   parameter int CNT_W = 40,
   parameter int EVT_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             dur_mode,
   input logic             pin_ovf,
   input logic             bkpt_mode,
   input logic [EVT_W-1:0] evt_num,
   input logic             cond_true,
   input logic             load_en,
   input logic [CNT_W-1:0] load_val,
   input logic             bkpt_hit,
   input logic [CNT_W-1:0] count_q,
   input logic             ovf_pulse,
   input logic             ind_pin
);
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> count_q == $past(load_val)); // R2
   AST_OCC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !dur_mode && !load_en && evt_num == EVT_W'(1)) |=> count_q == $past(count_q) + CNT_W'(1)); // R3
   AST_DUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && dur_mode && !load_en && !cond_true) |=> $stable(count_q)); // R4
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load_en) |=> $stable(count_q)); // R5
   AST_PIN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (!bkpt_mode && cnt_en && pin_ovf) |=> ind_pin == ovf_pulse); // R10
   AST_PIN_BKPT: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_mode |=> ind_pin == $past(bkpt_hit)); // R11
   AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!bkpt_mode && !cnt_en) |=> !ind_pin); // R12
endmodule

bind evt_tally_pin evt_tally_chk #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dur_mode(dur_mode),
   .pin_ovf(pin_ovf), .bkpt_mode(bkpt_mode), .evt_num(evt_num),
   .cond_true(cond_true), .load_en(load_en), .load_val(load_val),
   .bkpt_hit(bkpt_hit), .count_q(count_q), .ovf_pulse(ovf_pulse),
   .ind_pin(ind_pin)
);

// File: tb/evt_tally_pin_tb.sv
module evt_tally_pin_tb;
   localparam logic [40:0] TOP = 41'h100_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 0, dur_mode = 0, pin_ovf = 0, bkpt_mode = 0;
   logic [1:0]  evt_num = 0;
   logic        cond_true = 0, load_en = 0, bkpt_hit = 0;
   logic [39:0] load_val = '0;
   logic [39:0] count_q;
   logic        ovf_pulse, ind_pin;

   int n_chk = 0, n_bad = 0;

   logic [39:0] m_cnt;
   logic        m_pin;
   bit          hist[$];

   always #2 clk = ~clk;

   evt_tally_pin u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dur_mode(dur_mode),
      .pin_ovf(pin_ovf), .bkpt_mode(bkpt_mode), .evt_num(evt_num),
      .cond_true(cond_true), .load_en(load_en), .load_val(load_val),
      .bkpt_hit(bkpt_hit), .count_q(count_q), .ovf_pulse(ovf_pulse),
      .ind_pin(ind_pin)
   );

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_ovf();
      return (hist.size() == 5) ? hist[4] : 1'b0;
   endfunction

   // one clock: model update at the edge, compare at the falling edge
   task automatic cyc();
      int          amt;
      logic [40:0] sum;
      bit          wrap;
      string       creq, preq;
      @(posedge clk);
      amt = 0;
      if (cnt_en) amt = dur_mode ? int'(cond_true) : ((evt_num == 2'd3) ? 2 : int'(evt_num));
      creq = load_en ? "R2" : (!cnt_en ? "R5" : (dur_mode ? "R4" : "R3"));
      wrap = 0;
      if (load_en) begin
         m_cnt = load_val;
         amt = 0;
      end else begin
         sum = {1'b0, m_cnt} + 41'(amt);
         wrap = (sum >= TOP);
         if (wrap) creq = "R6";
         m_cnt = sum[39:0];
      end
      hist.push_front(wrap);
      if (hist.size() > 5) void'(hist.pop_back());
      if (bkpt_mode)     begin m_pin = bkpt_hit;  preq = "R11"; end
      else if (!cnt_en)  begin m_pin = 1'b0;      preq = "R12"; end
      else if (pin_ovf)  begin m_pin = exp_ovf(); preq = "R10"; end
      else               begin m_pin = (amt != 0); preq = dur_mode ? "R9" : "R8"; end
      @(negedge clk);
      check(creq, count_q, m_cnt);
      check("R7", 40'(ovf_pulse), 40'(exp_ovf()));
      check(preq, 40'(ind_pin), 40'(m_pin));
   endtask

   task automatic preset(input logic [39:0] v);
      load_en = 1; load_val = v; cyc(); load_en = 0;
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      m_cnt = '0; m_pin = 0;
      repeat (3) @(negedge clk);
      check("R1", count_q, 40'd0);
      check("R1", 40'(ovf_pulse), 40'd0);
      check("R1", 40'(ind_pin), 40'd0);
      rst_n = 1;

      // R3 R8 occurrence counting with increment indication
      cnt_en = 1;
      for (int i = 0; i < 40; i++) begin evt_num = 2'($urandom_range(0, 3)); cyc(); end
      // R4 R9 duration counting, evt_num ignored
      dur_mode = 1;
      for (int i = 0; i < 40; i++) begin
         evt_num = 2'($urandom_range(0, 3)); cond_true = 1'($urandom_range(0, 1)); cyc();
      end
      // R5 R12 disabled
      cnt_en = 0;
      for (int i = 0; i < 10; i++) begin
         evt_num = 2'd2; cond_true = 1; cyc();
      end
      // R6 R7 wrap of max plus two, then count-up-to in overflow mode (R10)
      cnt_en = 1; dur_mode = 0; evt_num = 0;
      preset(40'hFF_FFFF_FFFF);
      evt_num = 2'd2; cyc(); evt_num = 0;
      repeat (6) cyc();
      pin_ovf = 1;
      preset(40'hFF_FFFF_FFF6);
      evt_num = 2'd1;
      repeat (16) cyc();
      // R2 preset coinciding with a would-be wrap, disable during pending pulse
      preset(40'hFF_FFFF_FFFE);
      evt_num = 2'd3; load_en = 1; load_val = 40'hFF_FFFF_FFFF; cyc(); load_en = 0;
      cyc(); cnt_en = 0; repeat (6) cyc(); cnt_en = 1;
      // R11 breakpoint mode with counting running through a wrap
      bkpt_mode = 1; preset(40'hFF_FFFF_FFFC);
      for (int i = 0; i < 30; i++) begin
         evt_num = 2'($urandom_range(0, 3)); bkpt_hit = 1'($urandom_range(0, 1)); cyc();
      end
      // mixed random traffic near the top
      for (int i = 0; i < 3000; i++) begin
         cnt_en    = ($urandom_range(0, 7) != 0);
         dur_mode  = 1'($urandom_range(0, 1));
         pin_ovf   = 1'($urandom_range(0, 1));
         bkpt_mode = ($urandom_range(0, 5) == 0);
         evt_num   = 2'($urandom_range(0, 3));
         cond_true = 1'($urandom_range(0, 1));
         bkpt_hit  = 1'($urandom_range(0, 1));
         load_en   = ($urandom_range(0, 15) == 0);
         load_val  = 40'hFF_FFFF_FFFF - 40'($urandom_range(0, 6));
         cyc();
      end
      load_en = 0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule